// File: doc/BRIEF.md
# Tapped Wiper Position Controller

This block is the control logic behind a solid-state potentiometer with one hundred taps. It holds the wiper position as a small up/down counter. It turns that count into a one-hot select vector, which switches the transfer gates of the resistor ladder. Three asynchronous pins steer it:
- a select input;
- a direction input;
- an active-low step strobe.

All three are brought into the system clock domain before any edge detection is done.

Falling edges of the step strobe move the wiper one tap at a time, and only while the block is selected. The position saturates at both ends of the ladder. When the select is released while the strobe rests high, the current position is written to a registered nonvolatile cell through a one-cycle write strobe. After that, a busy window holds the wiper still. When reset is released, the block loads the saved value before it accepts any step, which models recall at power-up. A saved value outside the ladder is clamped to the top tap.

Top module: `wiper_ctl_top`

## Requirements
- R1: On the first rising clock edge after `rstN` goes high, `wiperPos` is loaded from `nvRdData`. A saved value below `NUM_TAPS` is taken unchanged.
- R2: A saved value of `NUM_TAPS` or more (for example 100 or 120) is loaded as `NUM_TAPS-1`.
- R3: With `chipSel` high, each falling edge of `stepN` with `upDn` high raises `wiperPos` by exactly one. The new value shows within five clock cycles of the edge.
- R4: With `chipSel` high, each falling edge of `stepN` with `upDn` low lowers `wiperPos` by exactly one.
- R5: A rising edge of `stepN` never moves the wiper.
- R6: While `chipSel` is low, edges on `stepN` leave `wiperPos` unchanged.
- R7: An up step at tap `NUM_TAPS-1` and a down step at tap 0 leave the position unchanged. The position never wraps.
- R8: `tapSel` always has exactly one bit set, and that bit's index equals `wiperPos`.
- R9: A falling edge of `chipSel` while `stepN` is high produces a single-cycle `nvWrEn` pulse. During that pulse `nvWrData` carries the current `wiperPos`.
- R10: A falling edge of `chipSel` while `stepN` is low produces no `nvWrEn` pulse.
- R11: `storeBusy` rises together with `nvWrEn` and stays high for exactly `STORE_CYCLES` cycles. Step edges that occur while it is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset; its release starts recall |
| chipSel | input | 1 | Select, active high, asynchronous |
| upDn | input | 1 | Step direction: 1 up, 0 down; asynchronous |
| stepN | input | 1 | Step strobe; a falling edge moves the wiper |
| nvRdData | input | POS_W | Saved position from the nonvolatile cell |
| nvWrEn | output | 1 | One-cycle write strobe to the nonvolatile cell |
| nvWrData | output | POS_W | Position to be saved |
| wiperPos | output | POS_W | Current wiper tap |
| tapSel | output | NUM_TAPS | One-hot tap select |
| storeBusy | output | 1 | High during the store window |

## Verification
The wiper is swept exhaustively. It goes up from a recalled mid value to the top tap and past it, then down across the whole ladder to tap 0 and past it. The bench checks the position and the full one-hot vector after every falling edge, and the unchanged position after every rising edge. This separates direction errors, off-by-one saturation bounds, wrap-around and a wrong decoder index. Deselected toggling and a deselect with the strobe low are checked separately from a real store. The store is checked twice: once to measure the pulse and the busy length, and once with a step attempted inside the busy window. Repeated resets with saved values 20, 0, 99, 100 and 120 test recall and the clamp boundary.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  // strobes from control to datapath, at most one of load/up/down/store per cycle
  typedef struct packed {
    logic load;
    logic up;
    logic down;
    logic store;
  } wiperCmd_t;
endpackage

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int STORE_CYCLES = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      chipSel,
  input  logic      upDn,
  input  logic      stepN,
  output wiperCmd_t cmd,
  output logic      storeBusy
);
  localparam int BUSY_W = $clog2(STORE_CYCLES + 1);

  logic [SYNC_STAGES-1:0] selSh, dirSh, stepSh;
  logic selS, dirS, stepS;
  logic selPrev, stepPrev, loaded;
  logic [BUSY_W-1:0] busyCnt;
  logic stepFall, selFall, accept, storeReq;

  assign selS  = selSh[SYNC_STAGES-1];
  assign dirS  = dirSh[SYNC_STAGES-1];
  assign stepS = stepSh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selSh    <= '0;
      dirSh    <= '0;
      stepSh   <= '1;
      selPrev  <= 1'b0;
      stepPrev <= 1'b1;
      loaded   <= 1'b0;
      busyCnt  <= '0;
    end else begin
      selSh    <= {selSh[SYNC_STAGES-2:0], chipSel};
      dirSh    <= {dirSh[SYNC_STAGES-2:0], upDn};
      stepSh   <= {stepSh[SYNC_STAGES-2:0], stepN};
      selPrev  <= selS;
      stepPrev <= stepS;
      loaded   <= 1'b1;
      if (storeReq)
        busyCnt <= BUSY_W'(STORE_CYCLES);
      else if (busyCnt != '0)
        busyCnt <= busyCnt - 1'b1;
    end
  end

  assign storeBusy = (busyCnt != '0);
  assign stepFall  = stepPrev & ~stepS;
  assign selFall   = selPrev & ~selS;
  assign accept    = loaded & selS & ~storeBusy;
  assign storeReq  = loaded & selFall & stepS & ~storeBusy;

  always_comb begin
    cmd       = '0;
    cmd.load  = ~loaded;
    cmd.up    = accept & stepFall & dirS;
    cmd.down  = accept & stepFall & ~dirS;
    cmd.store = storeReq;
  end
endmodule

// File: rtl/wiper_dp.sv
module wiper_dp
  import wiper_pkg::*;
#(
  parameter int NUM_TAPS = 100,
  parameter int POS_W    = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  wiperCmd_t           cmd,
  input  logic [POS_W-1:0]    nvRdData,
  output logic                nvWrEn,
  output logic [POS_W-1:0]    nvWrData,
  output logic [POS_W-1:0]    pos,
  output logic [NUM_TAPS-1:0] tapSel
);
  localparam logic [POS_W-1:0] TOP_TAP = POS_W'(NUM_TAPS - 1);

  logic [POS_W-1:0] recallVal;
  assign recallVal = (nvRdData > TOP_TAP) ? TOP_TAP : nvRdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos      <= '0;
      nvWrEn   <= 1'b0;
      nvWrData <= '0;
    end else begin
      nvWrEn <= cmd.store;
      if (cmd.store)
        nvWrData <= pos;
      if (cmd.load)
        pos <= recallVal;
      else if (cmd.up && pos != TOP_TAP)
        pos <= pos + 1'b1;
      else if (cmd.down && pos != '0)
        pos <= pos - 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign tapSel[i] = (pos == POS_W'(i));
  end
endmodule

// File: rtl/wiper_ctl_top.sv
module wiper_ctl_top
  import wiper_pkg::*;
#(
  parameter int NUM_TAPS     = 100,
  parameter int SYNC_STAGES  = 2,
  parameter int STORE_CYCLES = 32,
  parameter int POS_W        = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                chipSel,
  input  logic                upDn,
  input  logic                stepN,
  input  logic [POS_W-1:0]    nvRdData,
  output logic                nvWrEn,
  output logic [POS_W-1:0]    nvWrData,
  output logic [POS_W-1:0]    wiperPos,
  output logic [NUM_TAPS-1:0] tapSel,
  output logic                storeBusy
);
  wiperCmd_t cmd;

  wiper_ctrl #(.SYNC_STAGES(SYNC_STAGES), .STORE_CYCLES(STORE_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .upDn(upDn), .stepN(stepN),
    .cmd(cmd), .storeBusy(storeBusy)
  );

  wiper_dp #(.NUM_TAPS(NUM_TAPS), .POS_W(POS_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .nvRdData(nvRdData),
    .nvWrEn(nvWrEn), .nvWrData(nvWrData), .pos(wiperPos), .tapSel(tapSel)
  );
endmodule

// File: rtl/wiper_chk.sv
module wiper_chk #(
  parameter int NUM_TAPS = 100,
  parameter int POS_W    = $clog2(NUM_TAPS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                nvWrEn,
  input logic [POS_W-1:0]    nvWrData,
  input logic [POS_W-1:0]    wiperPos,
  input logic [NUM_TAPS-1:0] tapSel,
  input logic                storeBusy
);
  localparam logic [POS_W-1:0] TOP_TAP = POS_W'(NUM_TAPS - 1);

  logic [1:0] sinceRst;
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 1'b1;
  end
  assign armed = (sinceRst == 2'd2);

  // R8: decoded vector tracks the counter
  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(tapSel) && tapSel[wiperPos]);

  // R2: position stays inside the ladder
  assert_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    wiperPos <= TOP_TAP);

  // R3 and R4: single-tap moves after recall
  assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ((wiperPos >= $past(wiperPos)) ? (wiperPos - $past(wiperPos)) <= 1
                                              : ($past(wiperPos) - wiperPos) <= 1));

  // R7: no wrap at either end
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> !(($past(wiperPos) == TOP_TAP && wiperPos == '0) ||
                ($past(wiperPos) == '0 && wiperPos == TOP_TAP)));

  // R9: write strobe is one cycle wide and carries the position
  assert_wr_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    nvWrEn |=> !nvWrEn);
  assert_wr_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    nvWrEn |-> nvWrData == wiperPos);

  // R11: busy window starts with the write and freezes the wiper
  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    nvWrEn |-> storeBusy);
  assert_busy_freeze_R11: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(storeBusy)) |-> $stable(wiperPos));
endmodule

bind wiper_ctl_top wiper_chk #(.NUM_TAPS(NUM_TAPS), .POS_W(POS_W)) chk_i (
  .clk(clk), .rstN(rstN), .nvWrEn(nvWrEn), .nvWrData(nvWrData),
  .wiperPos(wiperPos), .tapSel(tapSel), .storeBusy(storeBusy)
);

// File: tb/wiper_ctl_top_tb_top.sv
`timescale 1ns/1ps
module wiper_ctl_top_tb_top;
  localparam int TAPS  = 100;
  localparam int PW    = $clog2(TAPS);
  localparam int SCYC  = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSel = 1'b0, upDn = 1'b0, stepN = 1'b1;
  logic [PW-1:0] nvCell = PW'(37);
  logic nvWrEn, storeBusy;
  logic [PW-1:0] nvWrData, wiperPos;
  logic [TAPS-1:0] tapSel;
  logic forceNv = 1'b0;
  logic [PW-1:0] forceVal = '0;
  int checks = 0, errors = 0, wrCount = 0, expPos = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wiper_ctl_top #(.NUM_TAPS(TAPS), .SYNC_STAGES(2), .STORE_CYCLES(SCYC)) dut_i (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .upDn(upDn), .stepN(stepN),
    .nvRdData(nvCell), .nvWrEn(nvWrEn), .nvWrData(nvWrData),
    .wiperPos(wiperPos), .tapSel(tapSel), .storeBusy(storeBusy)
  );

  // nonvolatile cell model
  always @(posedge clk) begin
    if (rstN && nvWrEn) begin
      nvCell  <= nvWrData;
      wrCount <= wrCount + 1;
    end else if (forceNv) nvCell <= forceVal;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkPos(input string req);
    logic [TAPS-1:0] v;
    v = '0;
    v[expPos] = 1'b1;
    check(int'(wiperPos) == expPos, req, int'(wiperPos), expPos);
    check(tapSel == v, "R8", $clog2(int'(tapSel)), expPos);
  endtask

  task automatic stepOnce(input bit up);
    upDn = up;
    tick(3);
    stepN = 1'b0;
    tick(5);
    if (up) expPos = (expPos < TAPS - 1) ? expPos + 1 : expPos;
    else    expPos = (expPos > 0) ? expPos - 1 : expPos;
    checkPos(up ? ((expPos == TAPS - 1) ? "R7" : "R3") : ((expPos == 0) ? "R7" : "R4"));
    stepN = 1'b1;
    tick(5);
    check(int'(wiperPos) == expPos, "R5", int'(wiperPos), expPos);
  endtask

  task automatic doReset(input int saved, input int expect_v, input string req);
    forceVal = PW'(saved);
    forceNv  = 1'b1;
    tick(1);
    forceNv  = 1'b0;
    rstN = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(3);
    expPos = expect_v;
    checkPos(req);
  endtask

  initial begin
    int wrBefore, pulses, busyLen, wrData;
    tick(3);
    rstN = 1'b1;
    tick(3);
    expPos = 37;
    checkPos("R1");
    chipSel = 1'b1;
    tick(5);
    // R3 R7: full upward sweep and beyond the top
    for (int i = 0; i < 65; i++) stepOnce(1'b1);
    // R4 R7: full downward sweep and beyond the bottom
    for (int i = 0; i < 104; i++) stepOnce(1'b0);
    for (int i = 0; i < 5; i++) stepOnce(1'b1);
    // R10: deselect with strobe low
    wrBefore = wrCount;
    upDn = 1'b1;
    tick(3);
    stepN = 1'b0;
    tick(5);
    expPos = expPos + 1;
    checkPos("R3");
    chipSel = 1'b0;
    tick(8);
    stepN = 1'b1;
    tick(8);
    check(wrCount == wrBefore, "R10", wrCount, wrBefore);
    // R6: toggling while deselected
    for (int i = 0; i < 4; i++) begin
      stepN = 1'b0; tick(5); stepN = 1'b1; tick(5);
    end
    check(int'(wiperPos) == expPos, "R6", int'(wiperPos), expPos);
    check(wrCount == wrBefore, "R10", wrCount, wrBefore);
    chipSel = 1'b1;
    tick(5);
    for (int i = 0; i < 14; i++) stepOnce(1'b1);
    // R9 R11: store and measure the pulse and busy window
    wrBefore = wrCount;
    pulses = 0; busyLen = 0; wrData = -1;
    chipSel = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (nvWrEn) begin pulses++; wrData = int'(nvWrData); end
      if (storeBusy) busyLen++;
    end
    check(pulses == 1, "R9", pulses, 1);
    check(wrData == expPos, "R9", wrData, expPos);
    check(int'(nvCell) == expPos, "R9", int'(nvCell), expPos);
    check(busyLen == SCYC, "R11", busyLen, SCYC);
    // R11: step attempted inside the busy window
    chipSel = 1'b1;
    tick(5);
    chipSel = 1'b0;
    tick(4);
    check(storeBusy == 1'b1, "R11", int'(storeBusy), 1);
    chipSel = 1'b1;
    upDn = 1'b1;
    tick(4);
    stepN = 1'b0;
    tick(5);
    stepN = 1'b1;
    tick(40);
    check(int'(wiperPos) == expPos, "R11", int'(wiperPos), expPos);
    check(wrCount == wrBefore + 2, "R9", wrCount, wrBefore + 2);
    // R1: recall of the stored value after more moves
    for (int i = 0; i < 3; i++) stepOnce(1'b1);
    forceVal = nvCell;
    doReset(int'(nvCell), 20, "R1");
    doReset(0, 0, "R1");
    doReset(99, 99, "R1");
    stepOnce(1'b1);
    // R2: clamp of out-of-range saved values
    doReset(100, 99, "R2");
    doReset(120, 99, "R2");
    stepOnce(1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule